// File: doc/BRIEF.md
# Banked Register Write Decoder

This block takes byte-wide host writes aimed at a small network controller and applies them to its register file. Sixteen byte offsets are shared by four banks. A bank select register picks which bank the offsets 0 to 13 reach. Offset 14 reaches the bank select register from every bank. The 16-bit registers are built from two byte writes, and a pointer/data window turns data writes into write requests for packet buffer memory.

Several functions sit outside the block: memory allocation commands, interrupt acknowledge and the receive FIFO itself. For these the block only raises one-cycle strobes carrying the written value. The receive FIFO head packet number comes in as an input. Every output is registered, so the effect of a write is visible in the cycle that follows the clock edge that takes the write.

Top module: `netregs_wr_decode`

## Requirements
- R1: A write to offset 14 loads all 8 bits of the bank select register, whatever the current bank. A write to offset 15 changes no register and raises no strobe.
- R2: In a decoded 16-bit register, a write to the even offset replaces the low byte and a write to the following odd offset replaces the high byte. The other byte keeps its value. The map is: bank 0 offsets 0/1 transmit control and 4/5 receive control; bank 1 offsets 0/1 configuration, 10/11 general purpose and 12/13 control; bank 2 offsets 6/7 pointer.
- R3: Writing the receive control high byte with bit 7 set (register bit 15) clears every register, including bank select, to zero. It also pulses `srst_stb` for one cycle.
- R4: A write to the low byte of the control register stores bits 1:0 as zero.
- R5: On a data write (bank 2, offsets 8 to 11), `buf_pkt` is `rx_head` when pointer bit 15 is 1. When bit 15 is 0, it is the packet number register (bank 2 offset 2).
- R6: When pointer bit 14 is 1, a data write uses pointer bits 10:0 as the address. Those 11 bits then step by one, wrapping from 0x7FF to 0x000, and pointer bits 15:11 stay unchanged.
- R7: When pointer bit 14 is 0, the address is pointer bits 10:0 plus (offset mod 4), taken modulo 2048. The pointer does not change.
- R8: A write to bank 3 offset 12 stores data bits 4:0 as the early-receive threshold.
- R9: These writes are accepted and change nothing, with no strobe: bank 0 offsets 10 and 11; bank 1 offsets 2 to 9; bank 2 offsets 1 and 3 to 5; bank 3 offsets 0 to 9 and 13.
- R10: A write to an offset that the selected bank does not decode changes nothing and pulses `bad_stb` for one cycle. This includes offsets 0 to 13 while bank select is above 3.
- R11: A write to bank 2 offset 0 pulses `cmd_stb` for one cycle, with `cmd_code` equal to data bits 7:5.
- R12: A write to bank 2 offset 12 pulses `ack_stb` with `ack_bits` equal to the data AND 0xD6. A write to bank 2 offset 13 stores the byte as the interrupt mask.
- R13: While `rst_n` is low, every register and every strobe is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host byte write valid |
| wr_off | input | 4 | Byte offset within the bank |
| wr_data | input | 8 | Write data byte |
| rx_head | input | PKT_W | Packet number at the receive FIFO head |
| bank_sel | output | 8 | Bank select register |
| tx_ctrl | output | 16 | Transmit control register |
| rx_ctrl | output | 16 | Receive control register |
| cfg_reg | output | 16 | Configuration register |
| gp_reg | output | 16 | General-purpose register |
| ctl_reg | output | 16 | Control register |
| pkt_sel | output | PKT_W | Packet number register |
| buf_ptr | output | 16 | Buffer pointer register |
| irq_mask | output | 8 | Interrupt mask register |
| erx_thresh | output | ERCV_W | Early-receive threshold |
| buf_we | output | 1 | Buffer write request (one cycle) |
| buf_pkt | output | PKT_W | Packet number of the buffer write |
| buf_addr | output | ADDR_W | Byte address of the buffer write |
| buf_data | output | 8 | Byte of the buffer write |
| cmd_stb | output | 1 | Memory command strobe |
| cmd_code | output | 3 | Memory command code |
| ack_stb | output | 1 | Interrupt acknowledge strobe |
| ack_bits | output | 8 | Acknowledged interrupt bits |
| srst_stb | output | 1 | Soft reset pulse |
| bad_stb | output | 1 | Undecoded register write pulse |

## Verification
The hardest state to reach from the ports is the 11-bit wrap of the auto-incrementing pointer when the pointer's upper five bits are not all zero. The stimulus gets there by loading the pointer with 0x5FFE through two byte writes and then issuing three data writes in a row. This shows whether the step wraps to 0x000 while bits 15:11 stay at 01011. A bank select value above 3 is a second corner. It is reached by writing 5 to offset 14, which tests that every offset except 14 and 15 then reports a bad register.

// File: rtl/netregs_pkg.sv
package netregs_pkg;

    typedef enum logic [4:0] {
        OP_IGNORE,
        OP_BAD,
        OP_BANK,
        OP_TCR_LO,
        OP_TCR_HI,
        OP_RCR_LO,
        OP_RCR_HI,
        OP_CFG_LO,
        OP_CFG_HI,
        OP_GPR_LO,
        OP_GPR_HI,
        OP_CTL_LO,
        OP_CTL_HI,
        OP_MMU,
        OP_PNR,
        OP_PTR_LO,
        OP_PTR_HI,
        OP_DATA,
        OP_ACK,
        OP_MASK,
        OP_ERCV
    } op_e;

    localparam logic [3:0] OFF_BANK = 4'd14;
    localparam logic [3:0] OFF_NOP  = 4'd15;

    localparam int NPAIR  = 5;
    localparam int PR_TCR = 0;
    localparam int PR_RCR = 1;
    localparam int PR_CFG = 2;
    localparam int PR_GPR = 3;
    localparam int PR_CTL = 4;

    localparam int SRST_BIT_HI = 7;
    localparam logic [7:0] ACK_KEEP = 8'hD6;
    localparam logic [7:0] CTL_LO_KEEP = 8'hFC;

endpackage

// File: rtl/netregs_op_decode.sv
module netregs_op_decode
    import netregs_pkg::*;
(
    input  logic [7:0] bank_q,
    input  logic [3:0] off,
    output op_e        op
);
    always_comb begin
        op = OP_BAD;
        if (off == OFF_BANK) begin
            op = OP_BANK;
        end else if (off == OFF_NOP) begin
            op = OP_IGNORE;
        end else begin
            unique case (bank_q)
                8'd0: begin
                    case (off)
                        4'd0:          op = OP_TCR_LO;
                        4'd1:          op = OP_TCR_HI;
                        4'd4:          op = OP_RCR_LO;
                        4'd5:          op = OP_RCR_HI;
                        4'd10, 4'd11:  op = OP_IGNORE;
                        default:       op = OP_BAD;
                    endcase
                end
                8'd1: begin
                    case (off)
                        4'd0:                      op = OP_CFG_LO;
                        4'd1:                      op = OP_CFG_HI;
                        4'd2, 4'd3, 4'd4, 4'd5,
                        4'd6, 4'd7, 4'd8, 4'd9:    op = OP_IGNORE;
                        4'd10:                     op = OP_GPR_LO;
                        4'd11:                     op = OP_GPR_HI;
                        4'd12:                     op = OP_CTL_LO;
                        4'd13:                     op = OP_CTL_HI;
                        default:                   op = OP_BAD;
                    endcase
                end
                8'd2: begin
                    case (off)
                        4'd0:                      op = OP_MMU;
                        4'd1, 4'd3, 4'd4, 4'd5:    op = OP_IGNORE;
                        4'd2:                      op = OP_PNR;
                        4'd6:                      op = OP_PTR_LO;
                        4'd7:                      op = OP_PTR_HI;
                        4'd8, 4'd9, 4'd10, 4'd11:  op = OP_DATA;
                        4'd12:                     op = OP_ACK;
                        4'd13:                     op = OP_MASK;
                        default:                   op = OP_BAD;
                    endcase
                end
                8'd3: begin
                    case (off)
                        4'd12:         op = OP_ERCV;
                        4'd10, 4'd11:  op = OP_BAD;
                        default:       op = OP_IGNORE;
                    endcase
                end
                default: op = OP_BAD;
            endcase
        end
    end
endmodule

// File: rtl/netregs_pair.sv
module netregs_pair #(
    parameter logic [7:0] LO_KEEP = 8'hFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        ld_lo,
    input  logic        ld_hi,
    input  logic [7:0]  wdata,
    output logic [15:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            q <= '0;
        end else begin
            if (ld_lo) q[7:0]  <= wdata & LO_KEEP;
            if (ld_hi) q[15:8] <= wdata;
        end
    end
endmodule

// File: rtl/netregs_ptr_unit.sv
module netregs_ptr_unit #(
    parameter int PKT_W  = 8,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic              data_wr,
    input  logic [1:0]        off_lo,
    input  logic [7:0]        wdata,
    input  logic [PKT_W-1:0]  rx_head,
    input  logic [PKT_W-1:0]  pkt_num,
    output logic [15:0]       ptr,
    output logic              buf_we,
    output logic [PKT_W-1:0]  buf_pkt,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [7:0]        buf_data
);
    localparam int RX_SEL_BIT = 15;
    localparam int AUTO_BIT   = 14;

    logic              auto_inc;
    logic [ADDR_W-1:0] base_addr;
    logic [ADDR_W-1:0] addr_nx;
    logic [ADDR_W-1:0] step_addr;
    logic [PKT_W-1:0]  pkt_nx;

    always_comb begin
        auto_inc  = ptr[AUTO_BIT];
        base_addr = ptr[ADDR_W-1:0];
        step_addr = base_addr + ADDR_W'(1);
        addr_nx   = auto_inc ? base_addr : base_addr + ADDR_W'(off_lo);
        pkt_nx    = ptr[RX_SEL_BIT] ? rx_head : pkt_num;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ptr <= '0;
        end else begin
            if (ld_lo) ptr[7:0]  <= wdata;
            if (ld_hi) ptr[15:8] <= wdata;
            if (data_wr && auto_inc) ptr[ADDR_W-1:0] <= step_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            buf_we   <= 1'b0;
            buf_pkt  <= '0;
            buf_addr <= '0;
            buf_data <= '0;
        end else begin
            buf_we <= data_wr;
            if (data_wr) begin
                buf_pkt  <= pkt_nx;
                buf_addr <= addr_nx;
                buf_data <= wdata;
            end
        end
    end
endmodule

// File: rtl/netregs_wr_decode.sv
module netregs_wr_decode
    import netregs_pkg::*;
#(
    parameter int PKT_W  = 8,
    parameter int ADDR_W = 11,
    parameter int ERCV_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        wr_off,
    input  logic [7:0]        wr_data,
    input  logic [PKT_W-1:0]  rx_head,
    output logic [7:0]        bank_sel,
    output logic [15:0]       tx_ctrl,
    output logic [15:0]       rx_ctrl,
    output logic [15:0]       cfg_reg,
    output logic [15:0]       gp_reg,
    output logic [15:0]       ctl_reg,
    output logic [PKT_W-1:0]  pkt_sel,
    output logic [15:0]       buf_ptr,
    output logic [7:0]        irq_mask,
    output logic [ERCV_W-1:0] erx_thresh,
    output logic              buf_we,
    output logic [PKT_W-1:0]  buf_pkt,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [7:0]        buf_data,
    output logic              cmd_stb,
    output logic [2:0]        cmd_code,
    output logic              ack_stb,
    output logic [7:0]        ack_bits,
    output logic              srst_stb,
    output logic              bad_stb
);
    op_e              op;
    op_e              op_act;
    logic             soft_clr;
    logic [NPAIR-1:0] pair_lo;
    logic [NPAIR-1:0] pair_hi;
    logic [15:0]      pair_q [NPAIR];

    netregs_op_decode u_dec (
        .bank_q (bank_sel),
        .off    (wr_off),
        .op     (op)
    );

    always_comb begin
        op_act   = wr_en ? op : OP_IGNORE;
        soft_clr = (op_act == OP_RCR_HI) && wr_data[SRST_BIT_HI];
        pair_lo  = '0;
        pair_hi  = '0;
        pair_lo[PR_TCR] = (op_act == OP_TCR_LO);
        pair_hi[PR_TCR] = (op_act == OP_TCR_HI);
        pair_lo[PR_RCR] = (op_act == OP_RCR_LO);
        pair_hi[PR_RCR] = (op_act == OP_RCR_HI);
        pair_lo[PR_CFG] = (op_act == OP_CFG_LO);
        pair_hi[PR_CFG] = (op_act == OP_CFG_HI);
        pair_lo[PR_GPR] = (op_act == OP_GPR_LO);
        pair_hi[PR_GPR] = (op_act == OP_GPR_HI);
        pair_lo[PR_CTL] = (op_act == OP_CTL_LO);
        pair_hi[PR_CTL] = (op_act == OP_CTL_HI);
    end

    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        netregs_pair #(
            .LO_KEEP((g == PR_CTL) ? CTL_LO_KEEP : 8'hFF)
        ) u_pair (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (soft_clr),
            .ld_lo (pair_lo[g]),
            .ld_hi (pair_hi[g]),
            .wdata (wr_data),
            .q     (pair_q[g])
        );
    end

    assign tx_ctrl = pair_q[PR_TCR];
    assign rx_ctrl = pair_q[PR_RCR];
    assign cfg_reg = pair_q[PR_CFG];
    assign gp_reg  = pair_q[PR_GPR];
    assign ctl_reg = pair_q[PR_CTL];

    netregs_ptr_unit #(
        .PKT_W  (PKT_W),
        .ADDR_W (ADDR_W)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (soft_clr),
        .ld_lo    (op_act == OP_PTR_LO),
        .ld_hi    (op_act == OP_PTR_HI),
        .data_wr  (op_act == OP_DATA),
        .off_lo   (wr_off[1:0]),
        .wdata    (wr_data),
        .rx_head  (rx_head),
        .pkt_num  (pkt_sel),
        .ptr      (buf_ptr),
        .buf_we   (buf_we),
        .buf_pkt  (buf_pkt),
        .buf_addr (buf_addr),
        .buf_data (buf_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            bank_sel   <= '0;
            pkt_sel    <= '0;
            irq_mask   <= '0;
            erx_thresh <= '0;
        end else begin
            unique case (op_act)
                OP_BANK: bank_sel   <= wr_data;
                OP_PNR:  pkt_sel    <= wr_data[PKT_W-1:0];
                OP_MASK: irq_mask   <= wr_data;
                OP_ERCV: erx_thresh <= wr_data[ERCV_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_stb  <= 1'b0;
            cmd_code <= '0;
            ack_stb  <= 1'b0;
            ack_bits <= '0;
            srst_stb <= 1'b0;
            bad_stb  <= 1'b0;
        end else begin
            cmd_stb  <= (op_act == OP_MMU);
            ack_stb  <= (op_act == OP_ACK);
            bad_stb  <= (op_act == OP_BAD);
            srst_stb <= soft_clr;
            if (op_act == OP_MMU) cmd_code <= wr_data[7:5];
            if (op_act == OP_ACK) ack_bits <= wr_data & ACK_KEEP;
        end
    end
endmodule

// File: rtl/netregs_wr_decode_chk.sv
module netregs_wr_decode_chk #(
    parameter int PKT_W  = 8,
    parameter int ADDR_W = 11,
    parameter int ERCV_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [3:0]        wr_off,
    input logic [7:0]        bank_sel,
    input logic [15:0]       tx_ctrl,
    input logic [15:0]       rx_ctrl,
    input logic [15:0]       cfg_reg,
    input logic [15:0]       gp_reg,
    input logic [15:0]       ctl_reg,
    input logic [15:0]       buf_ptr,
    input logic              buf_we,
    input logic              cmd_stb,
    input logic              ack_stb,
    input logic              srst_stb,
    input logic              bad_stb
);
    a_r14_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({buf_we, cmd_stb, ack_stb, srst_stb, bad_stb}));

    a_r10_bad_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        bad_stb |-> $past(wr_en));

    a_r10_bad_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_stb && $past(rst_n)) |-> ($stable(tx_ctrl) && $stable(rx_ctrl) &&
        $stable(cfg_reg) && $stable(gp_reg) && $stable(ctl_reg) &&
        $stable(bank_sel) && $stable(buf_ptr)));

    a_r1_off15_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && $past(wr_off) == 4'd15) |->
        (!cmd_stb && !ack_stb && !buf_we && !bad_stb && $stable(bank_sel)));

    a_r3_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
        srst_stb |-> (bank_sel == 8'd0 && rx_ctrl == 16'd0 && tx_ctrl == 16'd0 &&
        buf_ptr == 16'd0));

    a_r4_ctl_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_reg[1:0] == 2'b00);

    a_r6_ptr_top_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_we && $past(rst_n)) |-> (buf_ptr[15:11] == $past(buf_ptr[15:11])));

    a_r11_cmd_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |-> ($past(wr_en) && $past(wr_off) == 4'd0 && $past(bank_sel) == 8'd2));
endmodule

bind netregs_wr_decode netregs_wr_decode_chk #(
    .PKT_W  (PKT_W),
    .ADDR_W (ADDR_W),
    .ERCV_W (ERCV_W)
) u_chk (.*);

// File: tb/netregs_wr_decode_test.sv
module netregs_wr_decode_test;
    localparam int PKT_W  = 8;
    localparam int ADDR_W = 11;
    localparam int ERCV_W = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [3:0]        wr_off = '0;
    logic [7:0]        wr_data = '0;
    logic [PKT_W-1:0]  rx_head = '0;
    logic [7:0]        bank_sel;
    logic [15:0]       tx_ctrl, rx_ctrl, cfg_reg, gp_reg, ctl_reg, buf_ptr;
    logic [PKT_W-1:0]  pkt_sel, buf_pkt;
    logic [7:0]        irq_mask, buf_data, ack_bits;
    logic [ERCV_W-1:0] erx_thresh;
    logic              buf_we, cmd_stb, ack_stb, srst_stb, bad_stb;
    logic [ADDR_W-1:0] buf_addr;
    logic [2:0]        cmd_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    netregs_wr_decode #(.PKT_W(PKT_W), .ADDR_W(ADDR_W), .ERCV_W(ERCV_W)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
        .rx_head(rx_head), .bank_sel(bank_sel), .tx_ctrl(tx_ctrl), .rx_ctrl(rx_ctrl),
        .cfg_reg(cfg_reg), .gp_reg(gp_reg), .ctl_reg(ctl_reg), .pkt_sel(pkt_sel),
        .buf_ptr(buf_ptr), .irq_mask(irq_mask), .erx_thresh(erx_thresh),
        .buf_we(buf_we), .buf_pkt(buf_pkt), .buf_addr(buf_addr), .buf_data(buf_data),
        .cmd_stb(cmd_stb), .cmd_code(cmd_code), .ack_stb(ack_stb), .ack_bits(ack_bits),
        .srst_stb(srst_stb), .bad_stb(bad_stb)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the next negedge, after the taking edge.
    task automatic wr(input logic [3:0] o, input logic [7:0] d);
        wr_en = 1'b1; wr_off = o; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    function automatic logic [4:0] strobes();
        return {buf_we, cmd_stb, ack_stb, srst_stb, bad_stb};
    endfunction

    task automatic t_reset();
        check("R13 bank", bank_sel, 0);
        check("R13 regs", {tx_ctrl, rx_ctrl} | {cfg_reg, gp_reg} | {ctl_reg, buf_ptr}, 0);
        check("R13 small", {pkt_sel, irq_mask, 3'b0, erx_thresh}, 0);
        check("R13 strobes", strobes(), 0);
    endtask

    task automatic t_bank();
        wr(4'd14, 8'd1);
        check("R1 bank load", bank_sel, 1);
        wr(4'd15, 8'd3);
        check("R1 off15 bank", bank_sel, 1);
        check("R1 off15 strobes", strobes(), 0);
    endtask

    task automatic t_pairs();
        wr(4'd14, 8'd1);
        wr(4'd10, 8'hA5);
        check("R2 gp lo", gp_reg, 16'h00A5);
        wr(4'd11, 8'h3C);
        check("R2 gp hi", gp_reg, 16'h3CA5);
        wr(4'd10, 8'h11);
        check("R2 gp lo keeps hi", gp_reg, 16'h3C11);
        wr(4'd1, 8'h77);
        check("R2 cfg hi", cfg_reg, 16'h7700);
        wr(4'd14, 8'd0);
        wr(4'd0, 8'h12);
        wr(4'd1, 8'h34);
        check("R2 tcr", tx_ctrl, 16'h3412);
    endtask

    task automatic t_ctl();
        wr(4'd14, 8'd1);
        wr(4'd12, 8'hFF);
        wr(4'd13, 8'h81);
        check("R4 ctl low bits", ctl_reg, 16'h81FC);
    endtask

    task automatic t_ignored();
        logic [15:0] g;
        g = gp_reg;
        wr(4'd4, 8'hEE);
        check("R9 b1 off4 strobes", strobes(), 0);
        check("R9 b1 off4 gp", gp_reg, g);
        wr(4'd14, 8'd2);
        wr(4'd1, 8'h55);
        check("R9 b2 off1 strobes", strobes(), 0);
        wr(4'd3, 8'h55);
        wr(4'd5, 8'h55);
        check("R9 b2 off5 pkt", pkt_sel, 0);
        check("R9 b2 ptr", buf_ptr, 0);
        wr(4'd14, 8'd3);
        wr(4'd0, 8'h99);
        wr(4'd13, 8'h99);
        check("R9 b3 strobes", strobes(), 0);
        check("R9 b3 ercv", erx_thresh, 0);
        wr(4'd14, 8'd0);
        wr(4'd10, 8'h99);
        check("R9 b0 off10 strobes", strobes(), 0);
    endtask

    task automatic t_bad();
        logic [15:0] t;
        t = tx_ctrl;
        wr(4'd14, 8'd0);
        wr(4'd2, 8'hFF);
        check("R10 b0 off2 bad", strobes(), 5'b00001);
        check("R10 b0 tcr kept", tx_ctrl, t);
        idle();
        check("R10 one cycle", bad_stb, 0);
        wr(4'd14, 8'd3);
        wr(4'd10, 8'h01);
        check("R10 b3 off10 bad", bad_stb, 1);
        wr(4'd14, 8'd5);
        check("R10 bank5 loaded", bank_sel, 5);
        wr(4'd0, 8'hFF);
        check("R10 bank5 off0 bad", bad_stb, 1);
        check("R10 bank5 tcr kept", tx_ctrl, t);
        wr(4'd15, 8'h00);
        check("R10 bank5 off15 quiet", bad_stb, 0);
    endtask

    task automatic t_mmu_ack();
        wr(4'd14, 8'd2);
        wr(4'd0, 8'hC5);
        check("R11 cmd stb", cmd_stb, 1);
        check("R11 cmd code", cmd_code, 3'd6);
        idle();
        check("R11 one cycle", cmd_stb, 0);
        wr(4'd12, 8'hFF);
        check("R12 ack stb", ack_stb, 1);
        check("R12 ack bits", ack_bits, 8'hD6);
        wr(4'd13, 8'h5A);
        check("R12 mask", irq_mask, 8'h5A);
    endtask

    task automatic t_ptr_auto();
        wr(4'd14, 8'd2);
        wr(4'd2, 8'h21);
        wr(4'd6, 8'hFE);
        wr(4'd7, 8'h5F);
        check("R6 ptr load", buf_ptr, 16'h5FFE);
        wr(4'd8, 8'hA0);
        check("R6 we", buf_we, 1);
        check("R6 addr0", buf_addr, 11'h7FE);
        check("R5 pkt from pnr", buf_pkt, 8'h21);
        check("R6 data", buf_data, 8'hA0);
        check("R6 ptr step", buf_ptr, 16'h5FFF);
        wr(4'd11, 8'hA1);
        check("R6 addr1 ignores offset", buf_addr, 11'h7FF);
        wr(4'd9, 8'hA2);
        check("R6 addr wrap", buf_addr, 11'h000);
        check("R6 ptr wrap keeps top", buf_ptr, 16'h5801);
    endtask

    task automatic t_ptr_offset();
        wr(4'd6, 8'hFE);
        wr(4'd7, 8'h07);
        wr(4'd9, 8'hB0);
        check("R7 addr off1", buf_addr, 11'h7FF);
        wr(4'd11, 8'hB1);
        check("R7 addr wrap", buf_addr, 11'h001);
        check("R7 ptr fixed", buf_ptr, 16'h07FE);
    endtask

    task automatic t_rx_sel();
        rx_head = 8'h2A;
        wr(4'd6, 8'h10);
        wr(4'd7, 8'h80);
        wr(4'd10, 8'hC3);
        check("R5 pkt from rx head", buf_pkt, 8'h2A);
        check("R5 addr", buf_addr, 11'h012);
    endtask

    task automatic t_ercv();
        wr(4'd14, 8'd3);
        wr(4'd12, 8'hFF);
        check("R8 ercv", erx_thresh, 5'h1F);
        wr(4'd12, 8'h2A);
        check("R8 ercv low5", erx_thresh, 5'h0A);
    endtask

    task automatic t_soft_reset();
        wr(4'd14, 8'd0);
        wr(4'd4, 8'h34);
        wr(4'd5, 8'h7F);
        check("R3 no reset bit", rx_ctrl, 16'h7F34);
        check("R3 no pulse", srst_stb, 0);
        wr(4'd5, 8'h80);
        check("R3 pulse", srst_stb, 1);
        check("R3 rcr clear", rx_ctrl, 0);
        check("R3 tcr clear", tx_ctrl, 0);
        check("R3 others clear", {gp_reg, ctl_reg}, 0);
        check("R3 ptr mask ercv clear", {buf_ptr, irq_mask, 3'b0, erx_thresh}, 0);
        idle();
        check("R3 one cycle", srst_stb, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        idle();
        t_bank();
        t_pairs();
        t_ctl();
        t_ignored();
        t_bad();
        t_mmu_ack();
        t_ptr_auto();
        t_ptr_offset();
        t_rx_sel();
        t_ercv();
        t_soft_reset();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule